// File: doc/BRIEF.md
# Memory Write Protection Controller

This block sits beside the serial command engine of a small nonvolatile memory and decides, cycle by cycle, whether a memory byte write or a status write may go ahead. It combines three tiers of protection: an active-low hardware protect pin, a write-enable latch that clears itself when a write command finishes, and a two-bit block-protect field. The block-protect field guards none of the array, its upper quarter, its upper half, or all of it. The engine reports decoded command events. The block returns combinational permit signals, so that the array write can be gated in the same cycle, and it presents the status byte for readback.

The write-enable latch is held in a three-state machine. `LATCH_LOCKED` means writes are disabled. `LATCH_ARMED` means writes are enabled and no permitted write has happened yet in the current command. `LATCH_SPENT` means writes are still enabled but at least one permitted write has taken place, so the latch will drop when the command ends. The transitions are as follows:
- `arm`: LOCKED to ARMED, on set-enable.
- `disarm`: ARMED or SPENT to LOCKED, on clear-enable.
- `consume`: ARMED to SPENT, on a permitted write.
- `retire`: SPENT to LOCKED, on write-end.

A second machine tracks the byte in flight. `BYTE_IDLE` moves to `BYTE_ACTIVE` on byte-start, which is the `capture` transition and samples the pin level. `BYTE_ACTIVE` returns to `BYTE_IDLE` when the byte ends or the command ends, which is the `release` transition. While a byte is in flight, the captured pin level is used instead of the live pin.

The block-protect bits reset to a parameter value, which stands in for their nonvolatile contents.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset the latch is clear, the protect field equals `BP_INIT`, and `status_byte` reads {4'b0000, bp[1:0], latch, 1'b0}. Bits 7..4 and bit 0 are always 0.
- R2: A set-enable event sets the latch from the next cycle on. A clear-enable event clears it from the next cycle on. When both arrive in the same cycle, clear wins.
- R3: A permitted status write loads the protect field from `sr_data[3:2]`. All other data bits are ignored, and `sr_data[1]` in particular never changes the latch.
- R4: A status write that is not permitted leaves the protect field unchanged.
- R5: With the latch set and the effective pin high, `mem_permit` is 0 exactly when `mem_addr` lies in the protected range. Code 00 protects nothing, 01 protects 180h–1FFh, 10 protects 100h–1FFh, and 11 protects 000h–1FFh.
- R6: While the latch is clear, `mem_permit` and `sr_permit` are both 0.
- R7: While the effective pin is low, `mem_permit` and `sr_permit` are both 0.
- R8: The pin level captured at byte-start governs the permit until that byte ends. A pin change during the byte applies only to later bytes.
- R9: The latch stays set across several permitted bytes of one command. It clears in the cycle after write-end if that command contained at least one permitted write.
- R10: Write-end after a command with no permitted write leaves the latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wp_n | input | 1 | Active-low hardware write-protect pin |
| ev_set_en | input | 1 | Set-enable command decoded |
| ev_clr_en | input | 1 | Clear-enable command decoded |
| ev_byte_start | input | 1 | First bit of a data byte is arriving |
| ev_sr_wr | input | 1 | Status data byte complete |
| sr_data | input | 8 | Status data byte |
| ev_mem_wr | input | 1 | Memory data byte complete |
| mem_addr | input | ADDR_W | Address of the current memory byte |
| ev_wr_end | input | 1 | Chip select rose at the end of a write command |
| mem_permit | output | 1 | Memory byte write at `mem_addr` is allowed |
| sr_permit | output | 1 | Status write is allowed |
| status_byte | output | 8 | Status byte for readback |

## Verification
Several properties are checked by assertions on every cycle. A clear latch or a low effective pin suppresses both permits. Protect code 11 blocks every address. The protect field stays put unless a permitted status write loads it. Clear-enable and set-enable act on the next cycle. The captured pin level holds steady through a byte. Other behaviour can only be shown by the bench scenarios. These cover the exact boundary addresses of each protect range, the ignored data bits of a status write, the latch surviving several bytes and then dropping at write-end, and the pin falling part-way through a byte.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    typedef enum logic [1:0] {
        LATCH_LOCKED = 2'd0,
        LATCH_ARMED  = 2'd1,
        LATCH_SPENT  = 2'd2
    } latch_state_t;

    typedef enum logic {
        BYTE_IDLE   = 1'b0,
        BYTE_ACTIVE = 1'b1
    } byte_state_t;

    typedef logic [1:0] bp_code_t;

    localparam int unsigned SR_BP_LSB = 2;
    localparam int unsigned SR_LATCH_BIT = 1;

endpackage

// File: rtl/wprot_latch_fsm.sv
module wprot_latch_fsm
    import wprot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic clr_en,
    input  logic wr_done,
    input  logic wr_end,
    output logic wel
);

    latch_state_t state_q;
    latch_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LATCH_LOCKED: begin
                if (set_en && !clr_en) state_d = LATCH_ARMED;
            end
            LATCH_ARMED: begin
                if (clr_en)       state_d = LATCH_LOCKED;
                else if (wr_done) state_d = LATCH_SPENT;
            end
            LATCH_SPENT: begin
                if (clr_en || wr_end) state_d = LATCH_LOCKED;
            end
            default: state_d = LATCH_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LATCH_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        wel = (state_q != LATCH_LOCKED);
    end

    a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> !wel);

    a_r2_set_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !clr_en && !wr_end) |=> wel);

    a_r10_keep_unused: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LATCH_ARMED && wr_end && !wr_done && !clr_en) |=> wel);

endmodule

// File: rtl/wprot_byte_track.sv
module wprot_byte_track
    import wprot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wp_n,
    input  logic byte_start,
    input  logic byte_done,
    input  logic wr_end,
    output logic pin_eff
);

    byte_state_t state_q;
    byte_state_t state_d;
    logic        held_q;
    logic        held_d;

    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            BYTE_IDLE: begin
                if (byte_start) begin
                    state_d = BYTE_ACTIVE;
                    held_d  = wp_n;
                end
            end
            BYTE_ACTIVE: begin
                if (byte_start) begin
                    state_d = BYTE_ACTIVE;
                    held_d  = wp_n;
                end else if (byte_done || wr_end) begin
                    state_d = BYTE_IDLE;
                end
            end
            default: state_d = BYTE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BYTE_IDLE;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        pin_eff = (state_q == BYTE_ACTIVE) ? held_q : wp_n;
    end

    a_r8_frozen_in_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BYTE_ACTIVE && !byte_start && !byte_done && !wr_end)
            |=> $stable(pin_eff));

endmodule

// File: rtl/wprot_bp_reg.sv
module wprot_bp_reg
    import wprot_pkg::*;
#(
    parameter bp_code_t BP_INIT = 2'b00
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  bp_code_t load_val,
    output bp_code_t bp
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bp <= BP_INIT;
        else if (load) bp <= load_val;
    end

    a_r4_hold_unless_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bp));

endmodule

// File: rtl/wprot_range.sv
module wprot_range
    import wprot_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  bp_code_t          bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range
);

    localparam int unsigned TOP = ADDR_W - 1;

    always_comb begin
        unique case (bp)
            2'b00: in_range = 1'b0;
            2'b01: in_range = addr[TOP] & addr[TOP-1];
            2'b10: in_range = addr[TOP];
            2'b11: in_range = 1'b1;
            default: in_range = 1'b1;
        endcase
    end

endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl
    import wprot_pkg::*;
#(
    parameter int unsigned ADDR_W  = 9,
    parameter bp_code_t    BP_INIT = 2'b00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n,
    input  logic              ev_set_en,
    input  logic              ev_clr_en,
    input  logic              ev_byte_start,
    input  logic              ev_sr_wr,
    input  logic [7:0]        sr_data,
    input  logic              ev_mem_wr,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              ev_wr_end,
    output logic              mem_permit,
    output logic              sr_permit,
    output logic [7:0]        status_byte
);

    logic     wel;
    logic     pin_eff;
    logic     in_range;
    logic     wr_done;
    logic     sr_load;
    bp_code_t bp;
    logic     unused_sr_bits;

    assign unused_sr_bits = ^{sr_data[7:4], sr_data[1:0]};

    wprot_latch_fsm u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (ev_set_en),
        .clr_en  (ev_clr_en),
        .wr_done (wr_done),
        .wr_end  (ev_wr_end),
        .wel     (wel)
    );

    wprot_byte_track u_byte (
        .clk        (clk),
        .rst_n      (rst_n),
        .wp_n       (wp_n),
        .byte_start (ev_byte_start),
        .byte_done  (ev_mem_wr | ev_sr_wr),
        .wr_end     (ev_wr_end),
        .pin_eff    (pin_eff)
    );

    wprot_bp_reg #(.BP_INIT(BP_INIT)) u_bp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sr_load),
        .load_val (sr_data[SR_BP_LSB +: 2]),
        .bp       (bp)
    );

    wprot_range #(.ADDR_W(ADDR_W)) u_range (
        .bp       (bp),
        .addr     (mem_addr),
        .in_range (in_range)
    );

    always_comb begin
        sr_permit   = wel & pin_eff;
        mem_permit  = wel & pin_eff & ~in_range;
        sr_load     = ev_sr_wr & sr_permit;
        wr_done     = sr_load | (ev_mem_wr & mem_permit);
        status_byte = 8'h00;
        status_byte[SR_BP_LSB +: 2] = bp;
        status_byte[SR_LATCH_BIT]   = wel;
    end

    a_r6_latch_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !status_byte[SR_LATCH_BIT] |-> (!mem_permit && !sr_permit));

    a_r7_pin_gates: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_eff |-> (!mem_permit && !sr_permit));

    a_r5_full_block: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b11) |-> !mem_permit);

    a_r3_load_takes_field: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sr_wr && sr_permit) |=> (status_byte[3:2] == $past(sr_data[3:2])));

endmodule

// File: tb/test_wprot_ctrl.sv
module test_wprot_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_n = 1'b1;
    logic       ev_set_en = 1'b0;
    logic       ev_clr_en = 1'b0;
    logic       ev_byte_start = 1'b0;
    logic       ev_sr_wr = 1'b0;
    logic [7:0] sr_data = 8'h00;
    logic       ev_mem_wr = 1'b0;
    logic [8:0] mem_addr = 9'h000;
    logic       ev_wr_end = 1'b0;
    logic       mem_permit;
    logic       sr_permit;
    logic [7:0] status_byte;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wprot_ctrl i_wprot_ctrl (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
        .ev_set_en(ev_set_en), .ev_clr_en(ev_clr_en),
        .ev_byte_start(ev_byte_start), .ev_sr_wr(ev_sr_wr),
        .sr_data(sr_data), .ev_mem_wr(ev_mem_wr), .mem_addr(mem_addr),
        .ev_wr_end(ev_wr_end), .mem_permit(mem_permit),
        .sr_permit(sr_permit), .status_byte(status_byte)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sr_exp(input logic [1:0] bp, input logic wel);
        return {4'b0000, bp, wel, 1'b0};
    endfunction

    function automatic logic prot(input logic [1:0] bp, input logic [8:0] a);
        case (bp)
            2'b00: return 1'b0;
            2'b01: return a >= 9'h180;
            2'b10: return a >= 9'h100;
            default: return 1'b1;
        endcase
    endfunction

    task automatic pulse_set();
        @(negedge clk) ev_set_en = 1'b1;
        @(negedge clk) ev_set_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) ev_clr_en = 1'b1;
        @(negedge clk) ev_clr_en = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk) ev_wr_end = 1'b1;
        @(negedge clk) ev_wr_end = 1'b0;
    endtask

    task automatic status_write(input logic [7:0] d);
        @(negedge clk) ev_byte_start = 1'b1;
        @(negedge clk) begin
            ev_byte_start = 1'b0;
            ev_sr_wr = 1'b1;
            sr_data = d;
        end
        @(negedge clk) ev_sr_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 status", 16'(status_byte), 16'(sr_exp(2'b00, 1'b0)));
        check("R1 mem_permit", 16'(mem_permit), 16'd0);
        check("R1 sr_permit", 16'(sr_permit), 16'd0);
    endtask

    task automatic t_enable();
        pulse_set();
        check("R2 set", 16'(status_byte), 16'(sr_exp(2'b00, 1'b1)));
        pulse_clr();
        check("R2 clear", 16'(status_byte), 16'(sr_exp(2'b00, 1'b0)));
        @(negedge clk) begin
            ev_set_en = 1'b1;
            ev_clr_en = 1'b1;
        end
        @(negedge clk) begin
            ev_set_en = 1'b0;
            ev_clr_en = 1'b0;
        end
        check("R2 clear wins", 16'(status_byte[1]), 16'd0);
    endtask

    task automatic t_latch_zero();
        wp_n = 1'b1;
        mem_addr = 9'h000;
        @(negedge clk);
        check("R6 mem_permit", 16'(mem_permit), 16'd0);
        check("R6 sr_permit", 16'(sr_permit), 16'd0);
        status_write(8'h0C);
        check("R6/R4 bp held", 16'(status_byte), 16'(sr_exp(2'b00, 1'b0)));
    endtask

    task automatic t_ranges();
        logic [8:0] pts [6] = '{9'h000, 9'h0FF, 9'h100, 9'h17F, 9'h180, 9'h1FF};
        for (int c = 3; c >= 0; c--) begin
            pulse_set();
            status_write(8'hF3 | 8'(c << 2));
            check("R3 load, latch kept", 16'(status_byte), 16'(sr_exp(2'(c), 1'b1)));
            for (int k = 0; k < 6; k++) begin
                mem_addr = pts[k];
                #1;
                check("R5 range", 16'(mem_permit), 16'(!prot(2'(c), pts[k])));
            end
            pulse_end();
            check("R9 cleared after end", 16'(status_byte), 16'(sr_exp(2'(c), 1'b0)));
        end
    endtask

    task automatic t_pin_low();
        pulse_set();
        wp_n = 1'b0;
        mem_addr = 9'h010;
        @(negedge clk);
        check("R7 mem_permit", 16'(mem_permit), 16'd0);
        check("R7 sr_permit", 16'(sr_permit), 16'd0);
        status_write(8'h08);
        check("R4 bp unchanged", 16'(status_byte[3:2]), 16'd0);
        pulse_end();
        check("R10 latch kept", 16'(status_byte[1]), 16'd1);
        wp_n = 1'b1;
        pulse_clr();
    endtask

    task automatic t_midbyte();
        pulse_set();
        mem_addr = 9'h1F0;
        @(negedge clk) ev_byte_start = 1'b1;
        @(negedge clk) begin
            ev_byte_start = 1'b0;
            wp_n = 1'b0;
        end
        @(negedge clk);
        check("R8 byte keeps pin", 16'(mem_permit), 16'd1);
        ev_mem_wr = 1'b1;
        #1;
        check("R8 permit at byte end", 16'(mem_permit), 16'd1);
        @(negedge clk) ev_mem_wr = 1'b0;
        check("R8 new level after byte", 16'(mem_permit), 16'd0);
        pulse_end();
        check("R9 permitted byte clears", 16'(status_byte[1]), 16'd0);
        wp_n = 1'b1;
    endtask

    task automatic t_multi();
        pulse_set();
        for (int b = 0; b < 3; b++) begin
            mem_addr = 9'(9'h1FE + b);
            @(negedge clk) ev_byte_start = 1'b1;
            @(negedge clk) begin
                ev_byte_start = 1'b0;
                ev_mem_wr = 1'b1;
            end
            @(negedge clk) ev_mem_wr = 1'b0;
            check("R9 latch across bytes", 16'(status_byte[1]), 16'd1);
        end
        pulse_end();
        check("R9 cleared at end", 16'(status_byte[1]), 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_latch_zero();
        t_ranges();
        t_pin_low();
        t_midbyte();
        t_multi();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule